// File: doc/BRIEF.md
# Symmetric Polyphase Interpolate-by-3 FIR

This block raises the sample rate of a signed stream by a factor of three. For every input sample it emits three output samples. The result equals inserting two zeros after each input and then running an 11-tap filter at the output rate. The impulse response is symmetric: tap k equals tap 10-k. Only six coefficients are therefore independent, and they are supplied as a parameter vector.

The filter has no single input delay line. Each accepted sample is multiplied once by each independent coefficient. Each product is pushed into its own short delay line, which advances at the input rate. An output phase is the sum of selected entries from those product lines. Mirrored tap pairs therefore share one multiplication, so the filter needs six products per input, or two per output sample. When the center coefficient is declared unity, its multiplier is replaced by a plain sign extension, which leaves five products per input.

The input side is a low-rate valid/ready stream. The output side is a high-rate valid/ready stream that emits the phases in order. The block accepts a new sample only after all three outputs of the previous sample have been taken.

Top module: `fir3_sym_interp`

## Requirements
- R1: Every output equals, bit for bit and at full width (DW+CW+2 bits, no rounding), the corresponding sample of an 11-tap direct-form filter applied to the zero-stuffed input sequence x0,0,0,x1,0,0,...
- R2: Each accepted input produces exactly three outputs, delivered as phase 0, phase 1, phase 2. Phase p is the sum of h[k]*x[n-(k-p)/3] over k with k mod 3 = p.
- R3: The eleven taps are built from six coefficients in COEFS. Coefficient j sits at bits [j*CW +: CW] and supplies both tap j and tap 10-j, so a unit impulse yields h0..h5,h4..h0 over its first eleven outputs.
- R4: With CENTER_UNITY set, the center tap (index 5) is exactly 1 and is applied without a multiplier. Outputs then match the reference with h5 = 1.
- R5: out_valid rises in the cycle after an input handshake. in_ready is low whenever out_valid is high, and in_ready returns high in the cycle after the third output handshake.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R7: Synchronous reset clears all product history and restarts at phase 0. After reset, in_ready is 1 and out_valid is 0, and the first outputs reflect an all-zero history.
- R8: Extreme inputs (most negative and most positive DW-bit values) with extreme coefficients produce the exact sum without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a new input sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | DW+CW+2 | Signed full-precision output sample |

## Verification
An input accepted at a clock edge has its phase 0 output valid right after that edge. Each later phase appears right after the edge that completed the previous output handshake, and in_ready returns right after the edge of the third handshake. The bench drives inputs and out_ready at the falling edge and predicts which handshakes the next rising edge will perform. At every falling edge it compares in_ready, out_valid and the head of a queue of expected samples with the outputs. Those expected samples come from a zero-stuffed direct-form convolution, so held data under stalls and the recovery from reset are checked in the exact cycle where they are due.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
   localparam int FACTOR = 3;

   typedef enum logic [1:0] {
      PH0 = 2'd0,
      PH1 = 2'd1,
      PH2 = 2'd2
   } phase_t;

   function automatic int coef_count(input int ntaps);
      return (ntaps + 1) / 2;
   endfunction
endpackage

// File: rtl/fir3_prod_line.sv
// One independent coefficient: a single multiply per input sample, a delay
// line of products at the input rate, and its contribution to each phase.
module fir3_prod_line
   import fir3_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 16,
   parameter int NTAPS = 11,
   parameter int IDX = 0,
   parameter bit UNITY = 1'b0,
   parameter logic signed [CW-1:0] COEF = '0,
   localparam int PW = DW + CW,
   localparam int TW = PW + 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          shift,
   input  logic signed [DW-1:0]          din,
   output logic [FACTOR-1:0][TW-1:0]     terms
);
   localparam int MIR    = NTAPS - 1 - IDX;
   localparam int NEAR_P = IDX % FACTOR;
   localparam int NEAR_L = IDX / FACTOR;
   localparam int FAR_P  = MIR % FACTOR;
   localparam int FAR_L  = MIR / FACTOR;
   localparam int DEPTH  = FAR_L + 1;
   localparam bit PAIRED = (MIR != IDX);

   logic signed [PW-1:0]   dx;
   logic signed [PW-1:0]   prod;
   logic [DEPTH-1:0][PW-1:0] line;

   assign dx = PW'(din);

   generate
      if (UNITY) begin : g_bypass
         assign prod = dx;
      end else begin : g_mult
         logic signed [PW-1:0] cx;
         assign cx   = PW'(COEF);
         assign prod = dx * cx;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         line <= '0;
      end else if (shift) begin
         line[0] <= prod;
         for (int i = 1; i < DEPTH; i++) begin
            line[i] <= line[i-1];
         end
      end
   end

   generate
      for (genvar p = 0; p < FACTOR; p++) begin : g_phase
         if (NEAR_P == p && PAIRED && FAR_P == p) begin : g_both
            assign terms[p] = TW'($signed(line[NEAR_L])) + TW'($signed(line[FAR_L]));
         end else if (NEAR_P == p) begin : g_near
            assign terms[p] = TW'($signed(line[NEAR_L]));
         end else if (PAIRED && FAR_P == p) begin : g_far
            assign terms[p] = TW'($signed(line[FAR_L]));
         end else begin : g_none
            assign terms[p] = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/fir3_phase_seq.sv
// Sequencer: one input handshake, then three output phases, then ready again.
module fir3_phase_seq
   import fir3_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   in_valid,
   input  logic   out_ready,
   output logic   in_ready,
   output logic   out_valid,
   output phase_t phase,
   output logic   load
);
   logic   busy;
   phase_t ph;

   assign in_ready  = ~busy;
   assign load      = in_valid & ~busy;
   assign out_valid = busy;
   assign phase     = ph;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         ph   <= PH0;
      end else if (load) begin
         busy <= 1'b1;
         ph   <= PH0;
      end else if (busy && out_ready) begin
         if (ph == PH2) begin
            busy <= 1'b0;
            ph   <= PH0;
         end else begin
            ph <= phase_t'(ph + 2'd1);
         end
      end
   end
endmodule

// File: rtl/fir3_phase_sum.sv
// Adds the per-coefficient contributions for the phase being delivered.
module fir3_phase_sum
   import fir3_pkg::*;
#(
   parameter int NCOEF = 6,
   parameter int TW = 33,
   parameter int OW = 34
) (
   input  logic [NCOEF-1:0][FACTOR-1:0][TW-1:0] terms,
   input  phase_t                               phase,
   output logic signed [OW-1:0]                 y
);
   always_comb begin
      y = '0;
      for (int j = 0; j < NCOEF; j++) begin
         y = y + OW'($signed(terms[j][phase]));
      end
   end
endmodule

// File: rtl/fir3_sym_interp.sv
module fir3_sym_interp
   import fir3_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 16,
   parameter int NTAPS = 11,
   parameter bit CENTER_UNITY = 1'b0,
   parameter logic [((NTAPS+1)/2)*CW-1:0] COEFS =
      {16'h7918, 16'h4E20, 16'h2328, 16'hEC78, 16'h04B0, 16'h8000},
   localparam int OW = DW + CW + 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [DW-1:0] in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [OW-1:0] out_data
);
   localparam int NCOEF  = coef_count(NTAPS);
   localparam int CENTER = NCOEF - 1;
   localparam int PW     = DW + CW;
   localparam int TW     = PW + 1;

   generate
      if (NTAPS != 11) begin : g_bad_taps
         $error("fir3_sym_interp: NTAPS must be 11");
      end
      if (DW < 2 || CW < 2) begin : g_bad_width
         $error("fir3_sym_interp: DW and CW must be at least 2");
      end
      if (CENTER_UNITY && (COEFS[CENTER*CW +: CW] != CW'(1))) begin : g_bad_center
         $error("fir3_sym_interp: CENTER_UNITY needs the center coefficient equal to 1");
      end
   endgenerate

   phase_t phase;
   logic   load;
   logic [NCOEF-1:0][FACTOR-1:0][TW-1:0] terms;

   fir3_phase_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .phase     (phase),
      .load      (load)
   );

   generate
      for (genvar j = 0; j < NCOEF; j++) begin : g_line
         fir3_prod_line #(
            .DW    (DW),
            .CW    (CW),
            .NTAPS (NTAPS),
            .IDX   (j),
            .UNITY (CENTER_UNITY && (j == CENTER)),
            .COEF  (COEFS[j*CW +: CW])
         ) u_line (
            .clk   (clk),
            .rst   (rst),
            .shift (load),
            .din   (in_data),
            .terms (terms[j])
         );
      end
   endgenerate

   fir3_phase_sum #(
      .NCOEF (NCOEF),
      .TW    (TW),
      .OW    (OW)
   ) u_sum (
      .terms (terms),
      .phase (phase),
      .y     (out_data)
   );
endmodule

// File: rtl/fir3_sym_interp_chk.sv
module fir3_sym_interp_chk #(
   parameter int OW = 34
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [OW-1:0] out_data
);
   logic [1:0] delivered;

   always_ff @(posedge clk) begin
      if (rst) begin
         delivered <= 2'd0;
      end else if (in_valid && in_ready) begin
         delivered <= 2'd0;
      end else if (out_valid && out_ready && delivered != 2'd3) begin
         delivered <= delivered + 2'd1;
      end
   end

   // R5: input and output sides never active together
   p_excl_r5: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> !out_valid);

   // R5: first phase due one cycle after an input handshake
   p_resp_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

   // R2: third output handshake returns the block to ready
   p_three_r2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && delivered == 2'd2) |=> in_ready);

   // R2: never more than three outputs per input
   p_max_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (delivered != 2'd3));

   // R6: stalled output holds
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R7: reset leaves ready and no output pending
   p_reset_r7: assert property (@(posedge clk)
      rst |=> (in_ready && !out_valid));
endmodule

bind fir3_sym_interp fir3_sym_interp_chk #(.OW(OW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/sim_fir3_sym_interp.sv
`timescale 1ns/1ps
module sim_fir3_sym_interp;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic               out_ready = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               in_ready0, in_ready1, out_valid0, out_valid1;
   logic signed [33:0] out_data0, out_data1;

   int     checks = 0;
   int     fails = 0;
   bit     done = 1'b0;
   bit     stalled = 1'b0;
   string  tag = "R7 reset";
   longint zs[$];
   longint expa[$];
   longint expb[$];

   longint ha[11] = '{-32768, 1200, -5000, 9000, 20000, 31000, 20000, 9000, -5000, 1200, -32768};
   longint hb[11] = '{-32768, 1200, -5000, 9000, 20000, 1, 20000, 9000, -5000, 1200, -32768};

   fir3_sym_interp #(
      .CENTER_UNITY (1'b0),
      .COEFS        ({16'h7918, 16'h4E20, 16'h2328, 16'hEC78, 16'h04B0, 16'h8000})
   ) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready0), .in_data(in_data),
      .out_valid(out_valid0), .out_ready(out_ready), .out_data(out_data0)
   );

   fir3_sym_interp #(
      .CENTER_UNITY (1'b1),
      .COEFS        ({16'h0001, 16'h4E20, 16'h2328, 16'hEC78, 16'h04B0, 16'h8000})
   ) u1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready1), .in_data(in_data),
      .out_valid(out_valid1), .out_ready(out_ready), .out_data(out_data1)
   );

   // Direct form over the zero-stuffed history, newest sample first.
   function automatic longint conv(input longint h[11]);
      longint s = 0;
      for (int k = 0; k < 11; k++) begin
         if (k < zs.size()) s += h[k] * zs[k];
      end
      return s;
   endfunction

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic step(input bit rs, input bit v, input logic signed [15:0] d,
                       input bit r, output bit acc);
      @(negedge clk);
      chk(in_ready0 == (expa.size() == 0), {tag, " R5 in_ready u0"}, in_ready0, expa.size() == 0);
      chk(out_valid0 == (expa.size() != 0), {tag, " R5 out_valid u0"}, out_valid0, expa.size() != 0);
      chk(out_valid1 == (expb.size() != 0), {tag, " R5 out_valid u1"}, out_valid1, expb.size() != 0);
      if (out_valid0 && expa.size() != 0)
         chk(out_data0 == expa[0], {stalled ? "R6 held " : "", tag, " R2 phase data u0"},
             out_data0, expa[0]);
      if (out_valid1 && expb.size() != 0)
         chk(out_data1 == expb[0], {tag, " R4 unity center u1"}, out_data1, expb[0]);
      rst = rs;
      in_valid = v;
      in_data = d;
      out_ready = r;
      acc = 1'b0;
      if (rs) begin
         zs.delete();
         expa.delete();
         expb.delete();
         stalled = 1'b0;
      end else begin
         stalled = out_valid0 && !r;
         if (out_valid0 && r && expa.size() != 0) begin
            void'(expa.pop_front());
            if (expb.size() != 0) void'(expb.pop_front());
         end
         if (v && in_ready0) begin
            acc = 1'b1;
            zs.push_front(longint'(d));
            for (int p = 0; p < 3; p++) begin
               if (p > 0) zs.push_front(0);
               expa.push_back(conv(ha));
               expb.push_back(conv(hb));
            end
            while (zs.size() > 11) void'(zs.pop_back());
         end
      end
   endtask

   task automatic send(input logic signed [15:0] x, input int stall_pct, input int gap_pct);
      bit a = 1'b0;
      while (!a) begin
         step(1'b0, int'($urandom % 100) >= gap_pct, x, int'($urandom % 100) >= stall_pct, a);
      end
   endtask

   task automatic drain();
      bit a;
      repeat (6) step(1'b0, 1'b0, '0, 1'b1, a);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      bit a;
      // R7: reset state
      tag = "R7 reset";
      repeat (3) step(1'b1, 1'b0, '0, 1'b1, a);
      step(1'b0, 1'b0, '0, 1'b1, a);

      // R3: impulse exposes mirrored taps, R7: zero history after reset
      tag = "R3 R7 impulse";
      send(16'sd1, 0, 0);
      repeat (4) send(16'sd0, 0, 0);
      drain();

      // R1: random inputs, no stalls
      tag = "R1 random";
      for (int i = 0; i < 40; i++) send(16'($urandom), 0, 0);
      drain();

      // R1 R6: random inputs with output stalls and input gaps
      tag = "R1 R6 stalls";
      for (int i = 0; i < 60; i++) send(16'($urandom), 40, 30);
      drain();

      // R8: extreme values
      tag = "R8 extreme";
      for (int i = 0; i < 6; i++) send(16'sh8000, 20, 0);
      for (int i = 0; i < 6; i++) send((i % 2 == 0) ? 16'sh7FFF : 16'sh8000, 20, 0);
      drain();

      // R7: reset while phases are pending
      tag = "R7 midreset";
      for (int i = 0; i < 4; i++) send(16'($urandom), 0, 0);
      step(1'b0, 1'b0, '0, 1'b1, a);
      step(1'b1, 1'b0, '0, 1'b1, a);
      step(1'b0, 1'b0, '0, 1'b1, a);
      send(16'sd3, 0, 0);
      repeat (4) send(16'($urandom), 10, 10);
      drain();

      done = 1'b1;
      summary();
      $finish;
   end
endmodule